// File: doc/BRIEF.md
# Single-Branch Speculation Recovery Controller

This block lets an out-of-order core run ahead of one unresolved branch. It hands out a wrapping age sequence number to every instruction it accepts into the machine. It holds the register alias table that maps architectural registers to physical tags. The moment a branch is accepted, it copies the whole table into a checkpoint. Until that branch resolves, no second branch may enter, but ordinary instructions keep flowing and keep renaming.

When the branch resolves correctly, the block pulses a confirm strobe carrying the branch's sequence number, so the active instruction table can mark that branch ready. The speculative renames stay in place, and the next branch may enter on the following cycle.

When the branch resolves as mispredicted, recovery happens in that same single cycle. The block:
- raises a recovery strobe and a redirect with the correct fetch target;
- computes kill masks for the instruction window and the memory buffer from their entries' sequence numbers;
- blocks allocation;
- restores the alias table from the checkpoint at the next edge;
- rewinds the sequence counter to the number just after the branch.

Final architectural state is still committed only by in-order retirement elsewhere.

Allocation is a valid/ready stream:
- An instruction is accepted on a cycle where both `alloc_valid_i` and `alloc_ready_o` are high. It takes the number shown on `alloc_seq_o` in that cycle.
- `alloc_ready_o` falls during a recovery cycle. It also falls while a branch is unresolved and the offered instruction is itself a branch.
- A producer must hold its item stable until it is accepted.

Top module: `spec_recovery_ctrl`

## Requirements
- R1: After reset no branch is pending, `alloc_ready_o` is 1, `alloc_seq_o` is 0, and alias entry i holds physical tag i for every architectural register i.
- R2: Each accepted allocation receives the value on `alloc_seq_o`. The counter then advances by one, modulo 32 (5-bit numbers).
- R3: An accepted non-branch allocation with `alloc_wr_i` set writes `alloc_ptag_i` into alias entry `alloc_areg_i`, visible on the lookup port from the next cycle. A branch's destination fields are ignored.
- R4: Accepting a branch copies the alias table as it stood before that edge into the checkpoint. From the next cycle, `spec_active_o` is 1 and `spec_seq_o` holds the branch's sequence number.
- R5: While a branch is pending, an offered branch sees `alloc_ready_o` low and is not accepted, while non-branch allocations are still accepted.
- R6: A resolve with `res_ok_i`=1 while pending pulses `confirm_o` in that cycle with `spec_seq_o` naming the branch. No kill, redirect or restore occurs, the speculative renames are kept, and the pending state clears at the next edge.
- R7: A resolve with `res_ok_i`=0 while pending raises `recover_o` in that cycle with `redirect_pc_o` equal to `res_target_i`. From the next cycle the alias table equals the checkpoint and no branch is pending.
- R8: During recovery, a window or memory-buffer entry is killed exactly when it is valid and its sequence number is younger than the branch. Younger means (entry − branch) mod 32 lies in 1..15. Entry i's number sits in bits [5i+4:5i] of its sequence bus and its kill is bit i of the mask. The branch itself, older entries and invalid entries are never killed, including across the wrap from 31 to 0.
- R9: After recovery, the next accepted allocation receives the branch's sequence number plus one, modulo 32.
- R10: A resolve while no branch is pending has no effect: `confirm_o`, `recover_o` and both kill masks stay 0.
- R11: In a recovery cycle an offered allocation is not accepted. It writes nothing to the alias table and does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | An instruction is offered for allocation |
| alloc_ready_o | output | 1 | Allocation accepted this cycle if valid |
| alloc_is_br_i | input | 1 | Offered instruction is a predicted branch |
| alloc_wr_i | input | 1 | Offered instruction writes a destination |
| alloc_areg_i | input | 4 | Destination architectural register |
| alloc_ptag_i | input | 5 | Physical tag given to the destination |
| alloc_seq_o | output | 5 | Sequence number for the offered instruction |
| rd_areg_i | input | 4 | Alias lookup address |
| rd_ptag_o | output | 5 | Current physical tag of `rd_areg_i` |
| res_valid_i | input | 1 | Branch resolution strobe |
| res_ok_i | input | 1 | 1 = prediction correct, 0 = mispredicted |
| res_target_i | input | 32 | Correct fetch address on misprediction |
| spec_active_o | output | 1 | A branch is unresolved |
| spec_seq_o | output | 5 | Sequence number of the unresolved branch |
| confirm_o | output | 1 | Branch confirmed this cycle |
| recover_o | output | 1 | Recovery cycle: restore alias table, flush |
| redirect_pc_o | output | 32 | Fetch redirect target during recovery |
| win_vld_i | input | 16 | Valid bits of the instruction window |
| win_seq_i | input | 80 | Window sequence numbers, 5 bits per entry |
| win_kill_o | output | 16 | Window entries to invalidate |
| mem_vld_i | input | 16 | Valid bits of the memory buffer |
| mem_seq_i | input | 80 | Memory-buffer sequence numbers, 5 bits per entry |
| mem_kill_o | output | 16 | Memory-buffer entries to invalidate |

## Verification
Allocation is exercised with runs of plain renames, a run with a branch in flight, and a long run that carries the sequence counter across 31→0. The long run shows whether numbering is a true modulo count. A mispredicted branch is resolved against window and buffer contents that mix older, equal, younger and invalid entries, first near zero and then straddling the wrap. This separates a correct wrap-aware age test from a plain magnitude compare. A correctly predicted branch with younger valid entries present shows that confirmation keeps speculative renames and kills nothing. Resolves with no branch pending, and allocations offered during the recovery cycle, show that both are ignored.

// File: rtl/spec_pkg.sv
package spec_pkg;
  localparam int AREGS     = 16;
  localparam int AREG_W    = $clog2(AREGS);
  localparam int PTAG_W    = 5;
  localparam int WIN_DEPTH = 16;
  localparam int MEM_DEPTH = 16;
  localparam int SEQ_W     = $clog2(WIN_DEPTH) + 1;
  localparam int PC_W      = 32;

  typedef logic [SEQ_W-1:0] seq_t;

  // a is strictly younger than b when the modular distance is nonzero
  // and below half the number space (wrap bit of the difference clear)
  function automatic logic seq_younger(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/spec_seq_alloc.sv
module spec_seq_alloc
  import spec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic rewind_i,
  input  seq_t rewind_seq_i,
  output seq_t seq_o
);
  seq_t seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seq_q <= '0;
    else if (rewind_i) seq_q <= rewind_seq_i + seq_t'(1);
    else if (fire_i)   seq_q <= seq_q + seq_t'(1);
  end

  assign seq_o = seq_q;

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !rewind_i) |=> $stable(seq_q));
endmodule

// File: rtl/spec_rat.sv
module spec_rat
  import spec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AREG_W-1:0] waddr_i,
  input  logic [PTAG_W-1:0] wdata_i,
  input  logic              snap_i,
  input  logic              restore_i,
  input  logic [AREG_W-1:0] raddr_i,
  output logic [PTAG_W-1:0] rdata_o
);
  localparam int FLAT_W = AREGS * PTAG_W;

  logic [FLAT_W-1:0] tbl_q;
  logic [FLAT_W-1:0] ckpt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < AREGS; i++) tbl_q[i*PTAG_W +: PTAG_W] <= PTAG_W'(i);
    end else if (restore_i) begin
      tbl_q <= ckpt_q;
    end else if (we_i) begin
      tbl_q[waddr_i*PTAG_W +: PTAG_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ckpt_q <= '0;
    else if (snap_i) ckpt_q <= tbl_q;
  end

  assign rdata_o = tbl_q[raddr_i*PTAG_W +: PTAG_W];

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (tbl_q == $past(ckpt_q)));

  p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (ckpt_q == $past(tbl_q)));
endmodule

// File: rtl/spec_age_kill.sv
module spec_age_kill
  import spec_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               flush_i,
  input  seq_t               br_seq_i,
  input  logic [DEPTH-1:0]   vld_i,
  input  logic [DEPTH*SEQ_W-1:0] seq_i,
  output logic [DEPTH-1:0]   kill_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    seq_t ent_seq;
    assign ent_seq   = seq_i[g*SEQ_W +: SEQ_W];
    assign kill_o[g] = flush_i && vld_i[g] && seq_younger(ent_seq, br_seq_i);

    always_comb begin
      if (kill_o[g]) begin
        p_spare_branch_r8: assert (ent_seq != br_seq_i);
      end
    end
  end
endmodule

// File: rtl/spec_recovery_ctrl.sv
module spec_recovery_ctrl
  import spec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid_i,
  output logic                       alloc_ready_o,
  input  logic                       alloc_is_br_i,
  input  logic                       alloc_wr_i,
  input  logic [AREG_W-1:0]          alloc_areg_i,
  input  logic [PTAG_W-1:0]          alloc_ptag_i,
  output logic [SEQ_W-1:0]           alloc_seq_o,
  input  logic [AREG_W-1:0]          rd_areg_i,
  output logic [PTAG_W-1:0]          rd_ptag_o,
  input  logic                       res_valid_i,
  input  logic                       res_ok_i,
  input  logic [PC_W-1:0]            res_target_i,
  output logic                       spec_active_o,
  output logic [SEQ_W-1:0]           spec_seq_o,
  output logic                       confirm_o,
  output logic                       recover_o,
  output logic [PC_W-1:0]            redirect_pc_o,
  input  logic [WIN_DEPTH-1:0]       win_vld_i,
  input  logic [WIN_DEPTH*SEQ_W-1:0] win_seq_i,
  output logic [WIN_DEPTH-1:0]       win_kill_o,
  input  logic [MEM_DEPTH-1:0]       mem_vld_i,
  input  logic [MEM_DEPTH*SEQ_W-1:0] mem_seq_i,
  output logic [MEM_DEPTH-1:0]       mem_kill_o
);
  logic pending_q;
  seq_t br_seq_q;
  seq_t cur_seq;
  logic res_hit, recover, confirm, fire, br_fire, ren_we;

  assign res_hit = res_valid_i && pending_q;
  assign recover = res_hit && !res_ok_i;
  assign confirm = res_hit && res_ok_i;

  // one branch in flight; nothing enters during the recovery cycle
  assign alloc_ready_o = !recover && !(pending_q && alloc_is_br_i);
  assign fire    = alloc_valid_i && alloc_ready_o;
  assign br_fire = fire && alloc_is_br_i;
  assign ren_we  = fire && !alloc_is_br_i && alloc_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      br_seq_q  <= '0;
    end else begin
      if (recover || confirm) pending_q <= 1'b0;
      else if (br_fire)       pending_q <= 1'b1;
      if (br_fire) br_seq_q <= cur_seq;
    end
  end

  spec_seq_alloc u_seq (
    .clk, .rst_n,
    .fire_i      (fire),
    .rewind_i    (recover),
    .rewind_seq_i(br_seq_q),
    .seq_o       (cur_seq)
  );

  spec_rat u_rat (
    .clk, .rst_n,
    .we_i     (ren_we),
    .waddr_i  (alloc_areg_i),
    .wdata_i  (alloc_ptag_i),
    .snap_i   (br_fire),
    .restore_i(recover),
    .raddr_i  (rd_areg_i),
    .rdata_o  (rd_ptag_o)
  );

  spec_age_kill #(.DEPTH(WIN_DEPTH)) u_win_kill (
    .flush_i (recover), .br_seq_i(br_seq_q),
    .vld_i   (win_vld_i), .seq_i(win_seq_i), .kill_o(win_kill_o)
  );

  spec_age_kill #(.DEPTH(MEM_DEPTH)) u_mem_kill (
    .flush_i (recover), .br_seq_i(br_seq_q),
    .vld_i   (mem_vld_i), .seq_i(mem_seq_i), .kill_o(mem_kill_o)
  );

  assign alloc_seq_o   = cur_seq;
  assign spec_active_o = pending_q;
  assign spec_seq_o    = br_seq_q;
  assign confirm_o     = confirm;
  assign recover_o     = recover;
  assign redirect_pc_o = recover ? res_target_i : '0;

  p_one_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && fire) |-> !alloc_is_br_i);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (confirm_o || recover_o) |=> !spec_active_o);

  p_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover_o |=> (alloc_seq_o == $past(br_seq_q) + seq_t'(1)));

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_active_o |-> (!confirm_o && !recover_o && win_kill_o == '0 && mem_kill_o == '0));

  p_quiet_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    confirm_o |-> (win_kill_o == '0 && mem_kill_o == '0));
endmodule

// File: tb/test_spec_recovery_ctrl.sv
`timescale 1ns/1ps
module test_spec_recovery_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        alloc_valid_i = 0, alloc_is_br_i = 0, alloc_wr_i = 0;
  logic        alloc_ready_o;
  logic [3:0]  alloc_areg_i = 0, rd_areg_i = 0;
  logic [4:0]  alloc_ptag_i = 0, alloc_seq_o, rd_ptag_o, spec_seq_o;
  logic        res_valid_i = 0, res_ok_i = 0;
  logic [31:0] res_target_i = 0, redirect_pc_o;
  logic        spec_active_o, confirm_o, recover_o;
  logic [15:0] win_vld_i = 0, mem_vld_i = 0, win_kill_o, mem_kill_o;
  logic [79:0] win_seq_i = 0, mem_seq_i = 0;

  spec_recovery_ctrl i_spec_recovery_ctrl (.*);

  int n_tests = 0, n_fail = 0;
  int exp_seq = 0;
  int seq_q[$];

  task automatic chk(string req, longint act, longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: half a nanosecond before each rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && alloc_valid_i && alloc_ready_o) begin
      if (seq_q.size() == 0) chk("R11 unexpected accept", 1, 0);
      else chk("R2 alloc seq", alloc_seq_o, seq_q.pop_front());
    end
  end

  task automatic alloc(bit br, bit wr, int areg, int ptag);
    @(negedge clk);
    alloc_valid_i = 1; alloc_is_br_i = br; alloc_wr_i = wr;
    alloc_areg_i = 4'(areg); alloc_ptag_i = 5'(ptag);
    seq_q.push_back(exp_seq);
    exp_seq = (exp_seq + 1) % 32;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    alloc_valid_i = 0; res_valid_i = 0; alloc_is_br_i = 0; alloc_wr_i = 0;
  endtask

  task automatic lookup(string req, int areg, int exp);
    @(negedge clk);
    alloc_valid_i = 0; res_valid_i = 0;
    rd_areg_i = 4'(areg);
    #1 chk(req, rd_ptag_o, exp);
  endtask

  function automatic void put_seq(ref logic [79:0] bus, input int idx, input int s);
    bus[idx*5 +: 5] = 5'(s);
  endfunction

  initial begin
    #100000;
    chk("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 spec_active", spec_active_o, 0);
    chk("R1 ready", alloc_ready_o, 1);
    chk("R1 seq", alloc_seq_o, 0);
    for (int i = 0; i < 16; i++) lookup("R1 identity map", i, i);

    // R10 resolve with nothing pending
    @(negedge clk);
    res_valid_i = 1; res_ok_i = 0; res_target_i = 32'h1234; win_vld_i = 16'hFFFF;
    #1;
    chk("R10 no recover", recover_o, 0);
    chk("R10 no confirm", confirm_o, 0);
    chk("R10 no kill", win_kill_o, 0);
    idle();
    win_vld_i = 0;

    // R3 renames, seq 0..2
    alloc(0, 1, 2, 20);
    alloc(0, 1, 3, 21);
    alloc(0, 1, 5, 22);
    idle();
    lookup("R3 rename write", 2, 20);
    lookup("R3 rename write", 5, 22);

    // R4 branch at seq 3 with destination fields that must be ignored
    alloc(1, 1, 7, 30);
    idle();
    #1;
    chk("R4 spec_active", spec_active_o, 1);
    chk("R4 spec_seq", spec_seq_o, 3);
    lookup("R3 branch write ignored", 7, 7);

    // R5 second branch blocked, plain ones flow
    @(negedge clk);
    alloc_valid_i = 1; alloc_is_br_i = 1;
    #1 chk("R5 branch blocked", alloc_ready_o, 0);
    alloc(0, 1, 2, 25);  // seq 4
    alloc(0, 1, 9, 26);  // seq 5
    idle();
    lookup("R3 speculative write", 2, 25);

    // R7/R8/R11 mispredict
    @(negedge clk);
    win_vld_i = 16'b0000_0000_0000_1111;
    put_seq(win_seq_i, 0, 1); put_seq(win_seq_i, 1, 3);
    put_seq(win_seq_i, 2, 4); put_seq(win_seq_i, 3, 5);
    put_seq(win_seq_i, 4, 6);
    mem_vld_i = 16'b11; put_seq(mem_seq_i, 0, 2); put_seq(mem_seq_i, 1, 5);
    res_valid_i = 1; res_ok_i = 0; res_target_i = 32'hCAFE_0040;
    alloc_valid_i = 1; alloc_is_br_i = 0; alloc_wr_i = 1;
    alloc_areg_i = 11; alloc_ptag_i = 31;
    #1;
    chk("R7 recover", recover_o, 1);
    chk("R7 redirect pc", redirect_pc_o, 32'hCAFE_0040);
    chk("R11 ready low", alloc_ready_o, 0);
    chk("R8 window kill", win_kill_o, 16'b1100);
    chk("R8 membuf kill", mem_kill_o, 16'b10);
    exp_seq = 4;
    idle();
    #1;
    chk("R7 pending cleared", spec_active_o, 0);
    chk("R9 seq rewind", alloc_seq_o, 4);
    lookup("R7 restored", 2, 20);
    lookup("R7 restored", 9, 9);
    lookup("R11 no write", 11, 11);

    // advance to seq 30
    for (int k = 4; k < 30; k++) alloc(0, 0, 0, 0);
    alloc(1, 0, 0, 0);   // branch at 30
    alloc(0, 1, 6, 17);  // 31
    alloc(0, 0, 0, 0);   // 0
    alloc(0, 0, 0, 0);   // 1
    idle();
    #1 chk("R2 wrap", alloc_seq_o, 2);
    @(negedge clk);
    win_vld_i = 16'b0001_1111;
    put_seq(win_seq_i, 0, 29); put_seq(win_seq_i, 1, 30);
    put_seq(win_seq_i, 2, 31); put_seq(win_seq_i, 3, 0);
    put_seq(win_seq_i, 4, 14);
    mem_vld_i = 16'b111; put_seq(mem_seq_i, 0, 1); put_seq(mem_seq_i, 1, 30);
    put_seq(mem_seq_i, 2, 28);
    res_valid_i = 1; res_ok_i = 0; res_target_i = 32'h0000_0100;
    #1;
    chk("R8 wrap window kill", win_kill_o, 16'b01100);
    chk("R8 wrap membuf kill", mem_kill_o, 16'b001);
    exp_seq = 31;
    idle();
    #1 chk("R9 rewind over wrap", alloc_seq_o, 31);
    lookup("R7 wrap restore", 6, 6);

    // R6 confirm
    alloc(0, 1, 4, 10);  // 31
    alloc(1, 0, 0, 0);   // 0 branch
    alloc(0, 1, 4, 11);  // 1
    @(negedge clk);
    alloc_valid_i = 0;
    win_vld_i = 16'b11; put_seq(win_seq_i, 0, 1); put_seq(win_seq_i, 1, 0);
    res_valid_i = 1; res_ok_i = 1;
    #1;
    chk("R6 confirm", confirm_o, 1);
    chk("R6 confirm seq", spec_seq_o, 0);
    chk("R6 no recover", recover_o, 0);
    chk("R6 no kill", win_kill_o, 0);
    idle();
    #1 chk("R6 pending cleared", spec_active_o, 0);
    lookup("R6 renames kept", 4, 11);
    alloc(1, 0, 0, 0);   // seq 2
    idle();
    #1 chk("R6 next branch enters", spec_seq_o, 2);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", seq_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule